// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits inside a synchronous DRAM core. It turns a starting column and the burst settings into the run of column addresses for one read or write burst. A one-cycle start strobe captures the start column, a burst-length code, an ordering selector, the read/write direction and the read latency. From the next cycle on, the block presents one column address per enabled clock until the programmed number of columns has gone by or a stop strobe arrives. When a burst ends, a one-cycle done flag follows.

Fixed-length bursts stay inside the aligned block of their own length. They step through it either sequentially with wrap-around or in the order given by XOR of the start column with a running count. A full-page burst walks all 256 columns and wraps from the top back to column zero, forever, until it is stopped or restarted. For reads, a second flag marks the cycles in which read data is due. It is the address-valid flag of a read burst, delayed by the programmed latency of one to three enabled cycles. A low clock enable freezes the whole block.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, col_valid, rd_data_valid and burst_done are all 0.
- R2: len_code 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 columns, and 4 to 6 are treated as 1. A fixed burst keeps col_valid high for exactly that many enabled cycles, starting in the cycle after the start edge. burst_done is then high for one enabled cycle, the first one with col_valid low.
- R3: With seq_interleave=0, the i-th address of a fixed burst of length L from start column S is (S with its low log2(L) bits cleared) + ((S + i) mod L).
- R4: With seq_interleave=1, the i-th address of a fixed burst is (S with its low log2(L) bits cleared) + ((S XOR i) mod L).
- R5: len_code 7 selects full page. The i-th address is (S + i) mod 256, whatever seq_interleave is, and the burst never ends by itself.
- R6: A stop with clk_en high during a burst, and no start, drops col_valid in the next cycle and raises burst_done for one cycle. A stop while idle has no effect.
- R7: While clk_en is low, every output holds its value and start and stop are ignored.
- R8: A start during a burst restarts the sequence from the new start column, with the new settings and no burst_done pulse.
- R9: cas_lat 1, 2 and 3 give a read latency of that many cycles, and 0 is treated as 1. rd_data_valid equals col_valid of a read burst delayed by that many enabled cycles. A write burst (start_is_read=0) never raises it.
- R10: The settings are captured at the start edge. Changes to start_col, len_code, seq_interleave, start_is_read or cas_lat during a burst do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low suspends the block |
| start | input | 1 | One-cycle burst start strobe |
| start_is_read | input | 1 | 1 = read burst, 0 = write burst |
| start_col | input | 8 | Starting column |
| len_code | input | 3 | Burst length code (see R2, R5) |
| seq_interleave | input | 1 | 0 = sequential order, 1 = XOR order |
| cas_lat | input | 2 | Read latency in cycles |
| stop | input | 1 | Burst stop strobe |
| col_addr | output | 8 | Current column address (meaningful while col_valid) |
| col_valid | output | 1 | Column address is active |
| rd_data_valid | output | 1 | Read data due this cycle |
| burst_done | output | 1 | One-cycle pulse after a burst ends |

## Verification
The bench aims at start columns in the middle of their aligned block. There, a design that carries past the block boundary, or that adds where it should XOR, gives the wrong upper bits. It runs a full-page burst through the 255-to-0 wrap, which exposes a counter that stops or ends early. It drops clk_en in mid-burst while start and stop are asserted, so a design that leaks either strobe, or that advances the latency pipe during a suspend, shows a shifted address or data-valid edge. It also steps through every latency code, including the reserved 0, and through restarts and mid-burst setting changes. These expose a tap that is off by one, a done pulse raised on restart, or settings sampled live rather than captured.

// File: rtl/bcs_pkg.sv
// Shared types and helpers for the burst column address sequencer.
// Assumes an 8-bit column (256-column page) unless the user overrides COL_W.
package bcs_pkg;

    // Decoded burst length: full page flag and log2 of fixed length.
    typedef struct packed {
        logic       full;
        logic [2:0] lg;
    } len_dec_t;

    // Map the 3-bit length code: 0..3 -> 1,2,4,8; 7 -> full page; 4..6 -> 1.
    function automatic len_dec_t decode_len(input logic [2:0] code);
        len_dec_t d;
        d.full = (code == 3'd7);
        d.lg   = (code <= 3'd3) ? code : 3'd0;
        return d;
    endfunction

endpackage

// File: rtl/bcs_addr_gen.sv
// Combinational column address generator.
// Produces the column for running count cnt from the captured start column.
// Assumes cnt never exceeds the length mask for fixed bursts; the full page
// case uses an all-ones mask, so plain addition wraps over the whole page.
module bcs_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             xor_order,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] lo_lin;
    logic [COL_W-1:0] lo_xor;

    // Form the in-block offset for both orderings and pick one.
    always_comb begin
        lo_lin = (base + cnt) & mask;
        lo_xor = (base ^ cnt) & mask;
        addr   = (base & ~mask) | (xor_order ? lo_xor : lo_lin);
    end

endmodule

// File: rtl/bcs_lat_pipe.sv
// Read-latency delay line: shifts the read address-valid flag by a
// selectable number of enabled cycles (1..MAX_LAT). Freezes when en is low.
// Assumes sel is already normalised to the range 1..MAX_LAT.
module bcs_lat_pipe #(
    parameter int MAX_LAT = 3,
    localparam int SW = $clog2(MAX_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          din,
    input  logic [SW-1:0] sel,
    output logic          dout
);
    logic [MAX_LAT-1:0] stage;

    // One register per latency step, built by generate.
    for (genvar k = 0; k < MAX_LAT; k++) begin : g_stage
        if (k == 0) begin : g_first
            // First stage samples the incoming flag.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[0] <= 1'b0;
                else if (en) stage[0] <= din;
            end
        end else begin : g_rest
            // Later stages follow the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[k] <= 1'b0;
                else if (en) stage[k] <= stage[k-1];
            end
        end
    end

    // Tap selection by latency.
    always_comb begin
        dout = 1'b0;
        for (int j = 0; j < MAX_LAT; j++)
            if (int'(sel) == j + 1) dout = stage[j];
    end

endmodule

// File: rtl/burst_col_seq.sv
// Burst column address sequencer top.
// Captures burst settings on start, steps a column counter on each enabled
// clock, ends fixed bursts on length or stop, and delays the read valid flag
// by the captured latency. Assumes start/stop are single-cycle strobes and
// that col_addr is only meaningful while col_valid is high.
module burst_col_seq #(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3,
    localparam int LW     = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic             start_is_read,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             seq_interleave,
    input  logic [LW-1:0]    cas_lat,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             rd_data_valid,
    output logic             burst_done
);
    import bcs_pkg::*;

    logic             active_q;
    logic             done_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] cnt_q;
    len_dec_t         len_q;
    logic             xor_q;
    logic             rd_q;
    logic [LW-1:0]    lat_q;
    logic [COL_W-1:0] mask;
    logic             start_fire;
    logic             last_col;

    assign start_fire = start && clk_en;

    // Length mask: all ones for full page, else (1 << lg) - 1.
    always_comb begin
        if (len_q.full) mask = '1;
        else            mask = COL_W'((1 << len_q.lg) - 1);
        last_col = !len_q.full && (cnt_q == mask);
    end

    // Burst control: capture on start, step, end on length or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            len_q    <= '0;
            xor_q    <= 1'b0;
            rd_q     <= 1'b0;
            lat_q    <= LW'(1);
        end else if (clk_en) begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                base_q   <= start_col;
                cnt_q    <= '0;
                len_q    <= decode_len(len_code);
                xor_q    <= seq_interleave;
                rd_q     <= start_is_read;
                lat_q    <= (cas_lat == '0) ? LW'(1) : cas_lat;
            end else if (active_q) begin
                if (stop || last_col) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base      (base_q),
        .cnt       (cnt_q),
        .mask      (mask),
        .xor_order (xor_q && !len_q.full),
        .addr      (col_addr)
    );

    bcs_lat_pipe #(.MAX_LAT(MAX_LAT)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .din   (active_q && rd_q),
        .sel   (lat_q),
        .dout  (rd_data_valid)
    );

    assign col_valid  = active_q;
    assign burst_done = done_q;

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(col_addr) && $stable(col_valid) && $stable(burst_done))); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && stop && !start && col_valid) |=> (!col_valid && burst_done)); // R6

    AST_STAYS_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !len_q.full) |-> (((col_addr ^ base_q) & ~mask) == '0)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && burst_done) |=> !burst_done); // R2

    AST_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !start_fire && lat_q == LW'(1)) |=> (rd_data_valid == $past(col_valid && rd_q))); // R9

endmodule

// File: tb/burst_col_seq_tb_top.sv
// Self-checking bench: behavioural reference model compared every clock.
module burst_col_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       start = 1'b0;
    logic       start_is_read = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       seq_interleave = 1'b0;
    logic [1:0] cas_lat = 2'd1;
    logic       stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid, rd_data_valid, burst_done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
        .start_is_read(start_is_read), .start_col(start_col),
        .len_code(len_code), .seq_interleave(seq_interleave),
        .cas_lat(cas_lat), .stop(stop), .col_addr(col_addr),
        .col_valid(col_valid), .rd_data_valid(rd_data_valid),
        .burst_done(burst_done)
    );

    // Reference model state
    bit m_act, m_done, m_il, m_rd;
    int m_base, m_i, m_len, m_cl;
    bit hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_i = 0; m_cl = 1;
            hist = {0, 0, 0};
        end else if (clk_en) begin
            hist.push_front(m_act && m_rd);
            void'(hist.pop_back());
            m_done = 0;
            if (start) begin
                m_act = 1; m_i = 0; m_base = start_col;
                m_len = (len_code == 7) ? 0 : (len_code <= 3 ? (1 << len_code) : 1);
                m_il = seq_interleave; m_rd = start_is_read;
                m_cl = (cas_lat == 0) ? 1 : cas_lat;
            end else if (m_act) begin
                if (stop || (m_len != 0 && m_i == m_len - 1)) begin
                    m_act = 0; m_done = 1;
                end else m_i++;
            end
        end
    end

    function automatic int exp_addr();
        int lo;
        if (m_len == 0) return (m_base + m_i) % 256;
        lo = m_il ? ((m_base % m_len) ^ m_i) : ((m_base + m_i) % m_len);
        return m_base - (m_base % m_len) + lo;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("col_valid", col_valid, m_act);
            chk("burst_done", burst_done, m_done);
            chk("rd_data_valid", rd_data_valid, hist[m_cl-1]);
            if (m_act) chk("col_addr", col_addr, exp_addr());
        end
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(input bit rd, input int col, input int lc, input bit il, input int cl);
        start = 1; start_is_read = rd; start_col = 8'(col);
        len_code = 3'(lc); seq_interleave = il; cas_lat = 2'(cl);
        @(negedge clk);
        start = 0;
    endtask

    task automatic halt();
        stop = 1; @(negedge clk); stop = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("reset col_valid", col_valid, 0);
        chk("reset rd_data_valid", rd_data_valid, 0);
        chk("reset burst_done", burst_done, 0);

        cur_req = "R3";
        go(1, 8'h0E, 2, 0, 2); idle(8);
        go(0, 8'h35, 3, 0, 1); idle(12);

        cur_req = "R4";
        go(0, 8'h15, 3, 1, 1); idle(12);
        go(1, 8'h42, 2, 1, 3); idle(8);

        cur_req = "R2";
        for (int c = 0; c < 8; c++) begin
            if (c == 7) continue;
            go(1, 8'h33, c, c[0], 2); idle(11);
        end

        cur_req = "R5";
        go(1, 8'hFC, 7, 1, 3); idle(300);
        cur_req = "R6";
        halt(); idle(6);
        go(0, 8'h20, 3, 0, 1); idle(2); halt(); idle(5);
        halt(); halt(); idle(3);

        cur_req = "R7";
        go(1, 8'h61, 3, 0, 2); idle(2);
        clk_en = 0; stop = 1; start = 1; start_col = 8'h99;
        idle(4);
        stop = 0; start = 0; clk_en = 1;
        idle(3);
        clk_en = 0; idle(2); clk_en = 1;
        idle(12);

        cur_req = "R8";
        go(1, 8'h08, 3, 0, 2); idle(3);
        go(0, 8'hA3, 2, 1, 1); idle(1);
        go(1, 8'h10, 7, 0, 3); idle(5); halt(); idle(6);

        cur_req = "R9";
        for (int l = 0; l < 4; l++) begin
            go(1, 8'h50 + l, 2, 0, l); idle(9);
        end
        go(0, 8'h70, 3, 0, 3); idle(12);

        cur_req = "R10";
        go(1, 8'hC4, 3, 1, 2);
        len_code = 0; seq_interleave = 0; cas_lat = 3; start_is_read = 0; start_col = 8'h00;
        idle(13);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule